// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between the CPU-side register bus and a flash sequencer. It decides whether three flash operations may start: loading the on-chip programming routines ("download"), programming, and erasing. Software unlocks an operation in two steps. It sets an arming bit in the control/status register. It then writes the matching unlock code into the key register. Download and program/erase each take their own code. While the arming bit is clear, all three operations are locked.

While a program or erase runs, the block watches four event strobes: an interrupt request, a flash read, a sleep or standby request, and a bus grant to a master other than the CPU. Any of these is a sign of runaway or improper procedure. When one arrives, the block sends a one-cycle abort to the sequencer and drops busy. It also sets a sticky error flag, and that flag keeps program and erase locked until reset. The sequencer reports normal completion on `seq_done`.

Top module: `flash_guard`

## Requirements
- R1: After a synchronous reset, the following are all 0: every enable, `busy`, `abort`, `err_flag`, the arming bit and the key register.
- R2: `en_download` is 1 exactly when the arming bit (bit 0 of register 0) is 1 and the key register (register 1) holds 8'hA5. It follows the register contents one clock later.
- R3: `en_program` and `en_erase` are 1 exactly when the arming bit is 1, the key is 8'h5A and `err_flag` is 0. They follow one clock later.
- R4: Any other key value clears all three enables, so download and program/erase are never enabled together.
- R5: When not busy, a request whose enable is 1 starts an operation. `busy` rises on the next clock and `active_op` shows it (1 = download, 2 = program, 3 = erase; 0 = idle). If requests arrive together, program wins over erase, and erase wins over download. A request whose enable is 0 does nothing.
- R6: Any of the four event strobes during a program or erase makes `abort` 1 on the next clock. In that same cycle `busy` falls, `active_op` returns to 0 and `err_flag` sets.
- R7: `abort` is 1 for exactly one cycle per offending event.
- R8: `err_flag` stays set until reset. Writing register 0 does not clear it.
- R9: Event strobes while idle or during a download are ignored: no abort, no error, and a running download continues.
- R10: `seq_done` during an operation returns `busy` to 0 on the next clock, with no abort.
- R11: `cfg_rdata` shows the register selected by `cfg_addr` one clock later. Register 0 reads as {err_flag at bit 7, busy at bit 1, arming bit at bit 0}, with other bits 0. Register 1 reads back the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control/status, 1 key |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered readback of the selected register |
| evt_irq | input | 1 | Interrupt request strobe (maskable or not) |
| evt_flash_rd | input | 1 | Flash read strobe, including fetches and vector reads |
| evt_sleep | input | 1 | Sleep or standby request strobe |
| evt_ext_master | input | 1 | Bus granted to a master other than the CPU |
| req_download | input | 1 | Request to start a download |
| req_program | input | 1 | Request to start programming |
| req_erase | input | 1 | Request to start an erase |
| seq_done | input | 1 | Sequencer reports the running operation finished |
| en_download | output | 1 | Download permitted |
| en_program | output | 1 | Programming permitted |
| en_erase | output | 1 | Erase permitted |
| busy | output | 1 | An operation is running |
| active_op | output | 2 | Running operation code |
| abort | output | 1 | One-cycle abort to the sequencer |
| err_flag | output | 1 | Sticky error-protection flag |

## Verification
The assertions assume that requests, event strobes and `seq_done` are sampled on the rising edge as level signals held for whole cycles. They also assume the sequencer raises `seq_done` only while `busy` is 1. The bench drives every input on the falling edge and holds it for exactly one cycle. It pulses `seq_done` only after it has seen `busy` high. It resets the block before each error scenario, because the flag can only be cleared that way.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    OP_IDLE     = 2'd0,
    OP_DOWNLOAD = 2'd1,
    OP_PROGRAM  = 2'd2,
    OP_ERASE    = 2'd3
  } op_e;

  localparam int NUM_EVT    = 4;
  localparam int EVT_IRQ    = 0;
  localparam int EVT_READ   = 1;
  localparam int EVT_SLEEP  = 2;
  localparam int EVT_MASTER = 3;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_KEY  = 1'b1;

endpackage

// File: rtl/fg_regs.sv
module fg_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          err,
  input  logic          busy,
  output logic          arm,
  output logic [DW-1:0] key,
  output logic [DW-1:0] rdata
);
  import flash_guard_pkg::*;

  localparam int ARM_BIT  = 0;
  localparam int BUSY_BIT = 1;
  localparam int ERR_BIT  = DW - 1;

  logic [DW-1:0] status_view;

  always_comb begin
    status_view           = '0;
    status_view[ARM_BIT]  = arm;
    status_view[BUSY_BIT] = busy;
    status_view[ERR_BIT]  = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm   <= 1'b0;
      key   <= '0;
      rdata <= '0;
    end else begin
      if (we && addr == ADDR_CTRL) arm <= wdata[ARM_BIT];
      if (we && addr == ADDR_KEY)  key <= wdata;
      rdata <= (addr == ADDR_KEY) ? key : status_view;
    end
  end

  p_arm_write_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_CTRL) |=> (arm == $past(wdata[ARM_BIT])));

  p_key_write_r11: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_KEY) |=> (key == $past(wdata)));

endmodule

// File: rtl/fg_gate.sv
module fg_gate #(
  parameter int          DW     = 8,
  parameter logic [DW-1:0] KEY_DL = 8'hA5,
  parameter logic [DW-1:0] KEY_PE = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [DW-1:0] key,
  input  logic          err,
  output logic          en_dl,
  output logic          en_pe
);

  logic dl_ok, pe_ok;

  assign dl_ok = arm && (key == KEY_DL);
  assign pe_ok = arm && (key == KEY_PE) && !err;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_dl <= 1'b0;
      en_pe <= 1'b0;
    end else begin
      en_dl <= dl_ok;
      en_pe <= pe_ok;
    end
  end

  p_keys_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(en_dl && en_pe));

  p_err_locks_r3: assert property (@(posedge clk) disable iff (rst)
    err |=> !en_pe);

endmodule

// File: rtl/fg_errmon.sv
module fg_errmon #(
  parameter int NEVT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt,
  input  logic            pe_active,
  output logic            trip,
  output logic            abort,
  output logic            err
);

  assign trip = pe_active && (|evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      abort <= 1'b0;
      err   <= 1'b0;
    end else begin
      abort <= trip;
      if (trip) err <= 1'b1;
    end
  end

  p_trip_aborts_r6: assert property (@(posedge clk) disable iff (rst)
    (pe_active && (|evt)) |=> (abort && err));

  p_abort_single_r7: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_idle_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!pe_active && !err) |=> (!err && !abort));

endmodule

// File: rtl/fg_opctl.sv
module fg_opctl
  import flash_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_dl,
  input  logic req_pg,
  input  logic req_er,
  input  logic en_dl,
  input  logic en_pe,
  input  logic trip,
  input  logic done,
  output logic busy,
  output op_e  op,
  output logic pe_active
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      op   <= OP_IDLE;
    end else if (busy) begin
      if (trip || done) begin
        busy <= 1'b0;
        op   <= OP_IDLE;
      end
    end else if (req_pg && en_pe) begin
      busy <= 1'b1;
      op   <= OP_PROGRAM;
    end else if (req_er && en_pe) begin
      busy <= 1'b1;
      op   <= OP_ERASE;
    end else if (req_dl && en_dl) begin
      busy <= 1'b1;
      op   <= OP_DOWNLOAD;
    end
  end

  assign pe_active = busy && (op == OP_PROGRAM || op == OP_ERASE);

  p_start_prog_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_pg && en_pe) |=> (busy && op == OP_PROGRAM));

  p_done_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> !busy);

  p_trip_drops_busy_r6: assert property (@(posedge clk) disable iff (rst)
    trip |=> (!busy && op == OP_IDLE));

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY_DL = 8'hA5,
  parameter logic [DW-1:0] KEY_PE = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          evt_irq,
  input  logic          evt_flash_rd,
  input  logic          evt_sleep,
  input  logic          evt_ext_master,
  input  logic          req_download,
  input  logic          req_program,
  input  logic          req_erase,
  input  logic          seq_done,
  output logic          en_download,
  output logic          en_program,
  output logic          en_erase,
  output logic          busy,
  output logic [1:0]    active_op,
  output logic          abort,
  output logic          err_flag
);
  import flash_guard_pkg::*;

  logic                arm;
  logic [DW-1:0]       key;
  logic                en_dl, en_pe;
  logic                trip, pe_active;
  logic [NUM_EVT-1:0]  evt;
  op_e                 op;

  assign evt[EVT_IRQ]    = evt_irq;
  assign evt[EVT_READ]   = evt_flash_rd;
  assign evt[EVT_SLEEP]  = evt_sleep;
  assign evt[EVT_MASTER] = evt_ext_master;

  fg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .err(err_flag), .busy(busy), .arm(arm), .key(key), .rdata(cfg_rdata)
  );

  fg_gate #(.DW(DW), .KEY_DL(KEY_DL), .KEY_PE(KEY_PE)) u_gate (
    .clk(clk), .rst(rst), .arm(arm), .key(key), .err(err_flag),
    .en_dl(en_dl), .en_pe(en_pe)
  );

  fg_errmon #(.NEVT(NUM_EVT)) u_errmon (
    .clk(clk), .rst(rst), .evt(evt), .pe_active(pe_active),
    .trip(trip), .abort(abort), .err(err_flag)
  );

  fg_opctl u_opctl (
    .clk(clk), .rst(rst), .req_dl(req_download), .req_pg(req_program),
    .req_er(req_erase), .en_dl(en_dl), .en_pe(en_pe), .trip(trip),
    .done(seq_done), .busy(busy), .op(op), .pe_active(pe_active)
  );

  assign en_download = en_dl;
  assign en_program  = en_pe;
  assign en_erase    = en_pe;
  assign active_op   = op;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy && !abort && !err_flag && !en_download && !en_program));

  p_abort_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    abort |-> !busy);

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       evt_irq = 1'b0, evt_flash_rd = 1'b0, evt_sleep = 1'b0, evt_ext_master = 1'b0;
  logic       req_download = 1'b0, req_program = 1'b0, req_erase = 1'b0, seq_done = 1'b0;
  logic       en_download, en_program, en_erase, busy, abort, err_flag;
  logic [1:0] active_op;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .evt_irq(evt_irq), .evt_flash_rd(evt_flash_rd), .evt_sleep(evt_sleep),
    .evt_ext_master(evt_ext_master), .req_download(req_download),
    .req_program(req_program), .req_erase(req_erase), .seq_done(seq_done),
    .en_download(en_download), .en_program(en_program), .en_erase(en_erase),
    .busy(busy), .active_op(active_op), .abort(abort), .err_flag(err_flag)
  );

  // {arm, key, expected download enable, expected program/erase enable}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 8'hA5, 1'b1, 1'b0},
    {1'b1, 8'h5A, 1'b0, 1'b1},
    {1'b0, 8'hA5, 1'b0, 1'b0},
    {1'b0, 8'h5A, 1'b0, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'hFF, 1'b0, 1'b0},
    {1'b1, 8'hA4, 1'b0, 1'b0},
    {1'b1, 8'h5B, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {evt_irq, evt_flash_rd, evt_sleep, evt_ext_master} = '0;
    {req_download, req_program, req_erase, seq_done, cfg_we} = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // configure and let the registered enables settle
  task automatic setup(input logic armv, input logic [7:0] k);
    wr(1'b0, {7'd0, armv});
    wr(1'b1, k);
    @(negedge clk);
  endtask

  task automatic read_reg(input logic a, output logic [7:0] v);
    cfg_addr = a;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic fire_evt(input int idx);
    case (idx)
      0: evt_irq = 1'b1;
      1: evt_flash_rd = 1'b1;
      2: evt_sleep = 1'b1;
      default: evt_ext_master = 1'b1;
    endcase
    @(negedge clk);
    {evt_irq, evt_flash_rd, evt_sleep, evt_ext_master} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 abort", abort, 0);
    check("R1 err", err_flag, 0);
    check("R1 enables", {en_download, en_program, en_erase}, 0);
    read_reg(1'b1, rv); check("R1 key", rv, 8'h00);
    read_reg(1'b0, rv); check("R1 status", rv, 8'h00);

    // R2 R3 R4 key/arm table
    for (int i = 0; i < 8; i++) begin
      setup(VEC[i][10], VEC[i][9:2]);
      check($sformatf("R2 en_download vec%0d", i), en_download, VEC[i][1]);
      check($sformatf("R3 en_program vec%0d", i), en_program, VEC[i][0]);
      check($sformatf("R4 en_erase vec%0d", i), en_erase, VEC[i][0]);
    end

    // R11 readback
    setup(1'b1, 8'h5A);
    read_reg(1'b1, rv); check("R11 key readback", rv, 8'h5A);
    read_reg(1'b0, rv); check("R11 status armed idle", rv, 8'h01);

    // R5 program start and R10 completion
    req_program = 1'b1; @(negedge clk); req_program = 1'b0;
    check("R5 busy after program", busy, 1);
    check("R5 op program", active_op, 2);
    read_reg(1'b0, rv); check("R11 status busy", rv, 8'h03);
    seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;
    check("R10 busy cleared", busy, 0);
    check("R10 no abort", abort, 0);
    check("R10 op idle", active_op, 0);

    // R5 priority program over erase over download
    req_program = 1'b1; req_erase = 1'b1; req_download = 1'b1;
    @(negedge clk);
    {req_program, req_erase, req_download} = '0;
    check("R5 program wins", active_op, 2);
    seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;
    req_erase = 1'b1; req_download = 1'b1; @(negedge clk);
    {req_erase, req_download} = '0;
    check("R5 erase over download", active_op, 3);
    seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;

    // R5 refused without enable
    setup(1'b1, 8'h33);
    req_program = 1'b1; req_erase = 1'b1; req_download = 1'b1; @(negedge clk);
    {req_program, req_erase, req_download} = '0;
    check("R5 refused start", busy, 0);

    // R9 events while idle
    setup(1'b1, 8'h5A);
    for (int e = 0; e < 4; e++) begin
      fire_evt(e);
      check($sformatf("R9 idle abort evt%0d", e), abort, 0);
      check($sformatf("R9 idle err evt%0d", e), err_flag, 0);
    end

    // R9 events during download
    setup(1'b1, 8'hA5);
    req_download = 1'b1; @(negedge clk); req_download = 1'b0;
    check("R5 op download", active_op, 1);
    for (int e = 0; e < 4; e++) begin
      fire_evt(e);
      check($sformatf("R9 download abort evt%0d", e), abort, 0);
      check($sformatf("R9 download busy evt%0d", e), busy, 1);
    end
    check("R9 download err", err_flag, 0);
    seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;

    // R6 R7 R8 each event aborts program or erase
    for (int e = 0; e < 4; e++) begin
      do_reset();
      setup(1'b1, 8'h5A);
      if (e % 2 == 0) req_program = 1'b1; else req_erase = 1'b1;
      @(negedge clk);
      {req_program, req_erase} = '0;
      check($sformatf("R6 busy before evt%0d", e), busy, 1);
      fire_evt(e);
      check($sformatf("R6 abort evt%0d", e), abort, 1);
      check($sformatf("R6 busy dropped evt%0d", e), busy, 0);
      check($sformatf("R6 err set evt%0d", e), err_flag, 1);
      check($sformatf("R6 op idle evt%0d", e), active_op, 0);
      @(negedge clk);
      check($sformatf("R7 abort single evt%0d", e), abort, 0);
      check($sformatf("R3 locked by err evt%0d", e), en_program, 0);
    end

    // R8 sticky: write to status register, restart refused
    wr(1'b0, 8'h01);
    @(negedge clk);
    check("R8 err after write", err_flag, 1);
    read_reg(1'b0, rv); check("R8 status err bit", rv, 8'h81);
    req_program = 1'b1; @(negedge clk); req_program = 1'b0;
    check("R8 restart refused", busy, 0);
    repeat (3) @(negedge clk);
    check("R8 err holds", err_flag, 1);

    // R1 reset clears the flag
    do_reset();
    @(negedge clk);
    check("R1 err cleared by reset", err_flag, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule